// File: doc/BRIEF.md
# Dual-Target I2C Slave Controller

This block is an I2C slave that answers two 4-bit target IDs on the same bus. It samples the SCL and SDA lines with a fast system clock and finds START, repeated START and STOP conditions. It takes in the first byte of each transaction, decides whether to acknowledge it, and then routes the transfer to one of two address spaces. A byte-wide memory is reached through a two-byte address. A small register file is reached through a one-byte address, and any address past its last register is refused.

The block has no storage of its own for either space. It drives one-cycle write and read strobes, an address and write data to a memory port and to a register port. It takes the read data back on the same cycle as the read strobe. Each target keeps its own address pointer, so traffic to one target never moves the pointer of the other. SDA is driven open-drain through `sda_oe`; a high on `sda_oe` pulls the line low.

Top module: `i2c_dual_slave`

## Requirements
- R1: After reset, and one cycle after a STOP (SDA rising while SCL is high), `sda_oe` is low and the block waits for a START. A START (SDA falling while SCL is high) begins reception of a slave-address byte.
- R2: Slave-address bits 7:4 equal to 4'b1010 select the memory target and 4'b1101 select the register target. Any other value is not acknowledged (SDA stays released during the ninth clock).
- R3: Slave-address bits 2:1 must equal `dev_sel` for the byte to be acknowledged; bit 3 has no effect.
- R4: Slave-address bit 0 set to 1 starts a read: the slave sends data from the selected target's current address right after its acknowledge. Bit 0 set to 0 starts a write, and address bytes follow.
- R5: On a memory write the two bytes after the slave address form a 16-bit address, upper byte first. The pointer takes its low MEM_AW bits. Every following data byte is acknowledged and written with one `mem_wr` pulse.
- R6: The memory pointer advances by one after each data byte written or read, and wraps from 2^MEM_AW-1 to 0.
- R7: On a register write, one address byte follows. Values up to REG_LAST (18h) are acknowledged and loaded. A larger value is not acknowledged, leaves the register pointer unchanged, and every further byte is ignored and not acknowledged until the next START.
- R8: The register pointer advances after each data byte but stops at REG_LAST, so further writes land on REG_LAST and further reads repeat it.
- R9: On a read, each byte is followed by the master's acknowledge bit. A low bit makes the slave send the next byte. A high bit ends the read: SDA stays released until the next START.
- R10: Register-target traffic never changes the memory pointer.
- R11: A repeated START returns the block to slave-address reception and keeps both loaded pointers.
- R12: Data are shifted MSB first. `sda_oe` rises only while the synchronized SCL is low. It falls only while SCL is low, or right after a START or STOP.
- R13: At most one of `mem_wr`, `mem_rd`, `reg_wr`, `reg_rd` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low (ACK or data 0) |
| dev_sel | input | 2 | Device-select strap compared with slave-address bits 2:1 |
| mem_addr | output | MEM_AW | Memory pointer |
| mem_wr | output | 1 | One-cycle memory write strobe |
| mem_rd | output | 1 | One-cycle memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data for `mem_addr`, valid with `mem_rd` |
| reg_addr | output | REG_AW | Register pointer |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for `reg_addr`, valid with `reg_rd` |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, except for START and STOP. It holds each SCL level for several system clocks longer than the two-flop synchronizer delay. It never clocks while the slave is still changing SDA. The bench master meets these by holding each SCL phase for ten clocks. It moves SDA four clocks after SCL falls. It raises SCL only after the slave's one- or two-cycle drive update has settled, and it asks for a repeated START only after the slave has released SDA at the end of an acknowledge.

// File: rtl/i2c_dual_pkg.sv
package i2c_dual_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_LOAD,
    ST_TX,
    ST_MACK
  } slv_state_t;

  typedef enum logic [1:0] {
    K_DEV,
    K_AHI,
    K_ALO,
    K_DATA
  } byte_kind_t;

  localparam logic [3:0] TID_MEM = 4'hA;
  localparam logic [3:0] TID_REG = 4'hD;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_prev, sda_prev;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_ptr_unit.sv
module i2c_ptr_unit #(
  parameter int         MEM_AW   = 16,
  parameter int         REG_AW   = 5,
  parameter logic [7:0] REG_LAST = 8'h18
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              ld_hi,
  input  logic              ld_mem,
  input  logic              ld_reg,
  input  logic [7:0]        byte_i,
  input  logic              inc_mem,
  input  logic              inc_reg,
  output logic [MEM_AW-1:0] mem_ptr,
  output logic [REG_AW-1:0] reg_ptr
);

  localparam logic [REG_AW-1:0] REG_TOP = REG_LAST[REG_AW-1:0];

  logic [7:0]        hi_q, hi_n;
  logic [MEM_AW-1:0] mp_q, mp_n;
  logic [REG_AW-1:0] rp_q, rp_n;
  logic [15:0]       full_addr;

  assign full_addr = {hi_q, byte_i};

  always_comb begin
    hi_n = hi_q;
    mp_n = mp_q;
    rp_n = rp_q;
    if (ld_hi) hi_n = byte_i;
    if (ld_mem)       mp_n = full_addr[MEM_AW-1:0];
    else if (inc_mem) mp_n = mp_q + 1'b1;
    if (ld_reg)                          rp_n = byte_i[REG_AW-1:0];
    else if (inc_reg && rp_q != REG_TOP) rp_n = rp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hi_q <= '0;
      mp_q <= '0;
      rp_q <= '0;
    end else begin
      hi_q <= hi_n;
      mp_q <= mp_n;
      rp_q <= rp_n;
    end
  end

  assign mem_ptr = mp_q;
  assign reg_ptr = rp_q;

endmodule

// File: rtl/i2c_dual_slave.sv
module i2c_dual_slave
  import i2c_dual_pkg::*;
#(
  parameter int         MEM_AW      = 16,
  parameter logic [7:0] REG_LAST    = 8'h18,
  parameter int         SYNC_STAGES = 2,
  parameter int         REG_AW      = $clog2(int'(REG_LAST) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        dev_sel,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [REG_AW-1:0] reg_addr,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata
);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign arst_n = rst_pipe[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(arst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  slv_state_t st_q, st_n;
  byte_kind_t kind_q, kind_n;
  logic       tgt_q, tgt_n;     // 1: register target
  logic       rd_q, rd_n;
  logic [3:0] cnt_q, cnt_n;
  logic [7:0] sr_q, sr_n;
  logic       oe_q, oe_n;
  logic       wr_q, wr_n;
  logic       mack_q, mack_n;
  logic       ld_hi, ld_mem, ld_reg;
  logic       id_ok, id_reg;
  logic [7:0] rdata_sel;

  assign id_reg    = (sr_q[7:4] == TID_REG);
  assign id_ok     = ((sr_q[7:4] == TID_MEM) || id_reg) && (sr_q[2:1] == dev_sel);
  assign rdata_sel = tgt_q ? reg_rdata : mem_rdata;

  always_comb begin
    st_n   = st_q;
    kind_n = kind_q;
    tgt_n  = tgt_q;
    rd_n   = rd_q;
    cnt_n  = cnt_q;
    sr_n   = sr_q;
    oe_n   = oe_q;
    mack_n = mack_q;
    wr_n   = 1'b0;
    ld_hi  = 1'b0;
    ld_mem = 1'b0;
    ld_reg = 1'b0;
    if (start_det) begin
      st_n   = ST_RX;
      kind_n = K_DEV;
      cnt_n  = '0;
      oe_n   = 1'b0;
    end else if (stop_det) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sr_n  = {sr_q[6:0], sda_lvl};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            st_n = ST_ACK;
            oe_n = 1'b1;
            unique case (kind_q)
              K_DEV: begin
                if (id_ok) begin
                  tgt_n  = id_reg;
                  rd_n   = sr_q[0];
                  kind_n = sr_q[0] ? K_DATA : (id_reg ? K_ALO : K_AHI);
                end else begin
                  st_n = ST_IDLE;
                  oe_n = 1'b0;
                end
              end
              K_AHI: begin
                ld_hi  = 1'b1;
                kind_n = K_ALO;
              end
              K_ALO: begin
                if (!tgt_q) begin
                  ld_mem = 1'b1;
                  kind_n = K_DATA;
                end else if (sr_q <= REG_LAST) begin
                  ld_reg = 1'b1;
                  kind_n = K_DATA;
                end else begin
                  st_n = ST_IDLE;
                  oe_n = 1'b0;
                end
              end
              default: wr_n = 1'b1;
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            oe_n  = 1'b0;
            cnt_n = '0;
            st_n  = (rd_q && kind_q == K_DATA) ? ST_LOAD : ST_RX;
          end
        end
        ST_LOAD: begin
          sr_n  = rdata_sel;
          oe_n  = ~rdata_sel[7];
          cnt_n = '0;
          st_n  = ST_TX;
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_n = 1'b0;
              st_n = ST_MACK;
            end else begin
              sr_n  = {sr_q[6:0], 1'b0};
              oe_n  = ~sr_q[6];
              cnt_n = cnt_q + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_n = ~sda_lvl;
          if (scl_fall) st_n = mack_q ? ST_LOAD : ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_n_reset: begin
        st_q   <= ST_IDLE;
        kind_q <= K_DEV;
        tgt_q  <= 1'b0;
        rd_q   <= 1'b0;
        cnt_q  <= '0;
        sr_q   <= '0;
        oe_q   <= 1'b0;
        wr_q   <= 1'b0;
        mack_q <= 1'b0;
      end
    end else begin
      st_q   <= st_n;
      kind_q <= kind_n;
      tgt_q  <= tgt_n;
      rd_q   <= rd_n;
      cnt_q  <= cnt_n;
      sr_q   <= sr_n;
      oe_q   <= oe_n;
      wr_q   <= wr_n;
      mack_q <= mack_n;
    end
  end

  assign sda_oe    = oe_q;
  assign mem_wr    = wr_q & ~tgt_q;
  assign reg_wr    = wr_q & tgt_q;
  assign mem_rd    = (st_q == ST_LOAD) & ~tgt_q;
  assign reg_rd    = (st_q == ST_LOAD) & tgt_q;
  assign mem_wdata = sr_q;
  assign reg_wdata = sr_q;

  i2c_ptr_unit #(.MEM_AW(MEM_AW), .REG_AW(REG_AW), .REG_LAST(REG_LAST)) u_ptr (
    .clk(clk), .arst_n(arst_n),
    .ld_hi(ld_hi), .ld_mem(ld_mem), .ld_reg(ld_reg), .byte_i(sr_q),
    .inc_mem(mem_wr | mem_rd), .inc_reg(reg_wr | reg_rd),
    .mem_ptr(mem_addr), .reg_ptr(reg_addr)
  );

endmodule

// File: rtl/i2c_dual_slave_chk.sv
module i2c_dual_slave_chk #(
  parameter int         MEM_AW   = 16,
  parameter int         REG_AW   = 5,
  parameter logic [7:0] REG_LAST = 8'h18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_lvl,
  input logic              start_det,
  input logic              stop_det,
  input logic              mem_wr,
  input logic              mem_rd,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [REG_AW-1:0] reg_addr
);

  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  a_r12_drive_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);

  a_r12_release_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!scl_lvl || $past(stop_det) || $past(start_det)));

  a_r13_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wr, mem_rd, reg_wr, reg_rd}));

  a_r8_reg_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(reg_addr) <= int'(REG_LAST));

  a_r8_reg_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_wr || reg_rd) && int'(reg_addr) == int'(REG_LAST))
      |=> int'(reg_addr) == int'(REG_LAST));

  a_r10_mem_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |=> $stable(mem_addr));

  a_r6_mem_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_wr || mem_rd) && (&mem_addr)) |=> (mem_addr == '0));

endmodule

bind i2c_dual_slave i2c_dual_slave_chk #(
  .MEM_AW(MEM_AW), .REG_AW(REG_AW), .REG_LAST(REG_LAST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_lvl(scl_lvl),
  .start_det(start_det), .stop_det(stop_det),
  .mem_wr(mem_wr), .mem_rd(mem_rd), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .mem_addr(mem_addr), .reg_addr(reg_addr)
);

// File: tb/sim_i2c_dual_slave.sv
module sim_i2c_dual_slave;

  localparam int AW   = 10;
  localparam int NMEM = 1 << AW;
  localparam int NREG = 25;
  localparam int T    = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, m_scl, m_sda, sda_line, sda_oe;
  logic [1:0]    dev_sel;
  logic [AW-1:0] mem_addr;
  logic          mem_wr, mem_rd, reg_wr, reg_rd;
  logic [7:0]    mem_wdata, mem_rdata, reg_wdata, reg_rdata;
  logic [4:0]    reg_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] mem_m [NMEM];
  logic [7:0] reg_m [NREG];
  logic [7:0] exp_mem [NMEM];
  logic [7:0] exp_reg [NREG];

  assign sda_line = m_sda & ~sda_oe;

  i2c_dual_slave #(.MEM_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .dev_sel(dev_sel), .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NMEM; i++) mem_m[i] <= 8'(i * 7 + 3);
      for (int i = 0; i < NREG; i++) reg_m[i] <= 8'(i * 11 + 1);
    end else begin
      if (mem_wr) mem_m[mem_addr] <= mem_wdata;
      if (reg_wr && int'(reg_addr) < NREG) reg_m[reg_addr] <= reg_wdata;
    end
  end

  assign mem_rdata = mem_m[mem_addr];
  assign reg_rdata = (int'(reg_addr) < NREG) ? reg_m[reg_addr] : 8'h00;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_bit(input logic b, output logic r);
    m_sda = b;
    waitc(T);
    m_scl = 1'b1;
    waitc(T);
    r = sda_line;
    m_scl = 1'b0;
    waitc(4);
  endtask

  task automatic bus_start;
    m_sda = 1'b1;
    waitc(4);
    m_scl = 1'b1;
    waitc(T);
    m_sda = 1'b0;
    waitc(T);
    m_scl = 1'b0;
    waitc(4);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0;
    waitc(4);
    m_scl = 1'b1;
    waitc(T);
    m_sda = 1'b1;
    waitc(T);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], r);
    bus_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, r);
      d[i] = r;
    end
    bus_bit(~mack, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog all requirements actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic       a, r, hi_seen;
    logic [7:0] d, v;
    int         mp, rp, g;
    logic [7:0] bad_addr [4];

    bad_addr[0] = 8'h19; bad_addr[1] = 8'h1A; bad_addr[2] = 8'h40; bad_addr[3] = 8'hFF;
    for (int i = 0; i < NMEM; i++) exp_mem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < NREG; i++) exp_reg[i] = 8'(i * 11 + 1);

    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; dev_sel = 2'b10;
    waitc(6);
    // R1 reset state
    chk("R1 reset sda_oe", 32'(sda_oe), 32'd0);
    chk("R13 reset strobes", 32'({mem_wr, mem_rd, reg_wr, reg_rd}), 32'd0);
    rst_n = 1'b1;
    waitc(6);

    // R2 R3: sweep every ID against every select value (dev_sel = 2'b10)
    for (int id = 0; id < 16; id++) begin
      for (int sel = 0; sel < 4; sel++) begin
        bus_start;
        put_byte({4'(id), 1'(id), 2'(sel), 1'b0}, a);
        bus_stop;
        chk("R2 R3 slave address ack", 32'(a),
            32'(((id == 10) || (id == 13)) && (sel == 2)));
      end
    end

    // R5 R6: memory write across the top of the space (0xFBF8 -> 0x3F8)
    bus_start;
    put_byte(8'hAC, a); chk("R3 bit3 ignored ack", 32'(a), 32'd1);
    put_byte(8'hFB, a); chk("R5 addr hi ack", 32'(a), 32'd1);
    put_byte(8'hF8, a); chk("R5 addr lo ack", 32'(a), 32'd1);
    mp = 'h3F8;
    for (int k = 0; k < 12; k++) begin
      v = 8'(k * 37 + 5);
      put_byte(v, a);
      chk("R5 data ack", 32'(a), 32'd1);
      exp_mem[mp] = v;
      mp = (mp + 1) % NMEM;
    end
    bus_stop;

    // R11 R4 R6 R12: reload pointer, repeated START, read back
    bus_start;
    put_byte(8'hA4, a);
    put_byte(8'h03, a);
    put_byte(8'hF8, a);
    mp = 'h3F8;
    bus_start;
    put_byte(8'hA5, a); chk("R4 R11 read address ack", 32'(a), 32'd1);
    for (int k = 0; k < 12; k++) begin
      get_byte(k != 11, d);
      chk("R6 R12 memory read data", 32'(d), 32'(exp_mem[mp]));
      mp = (mp + 1) % NMEM;
    end
    // R9: after master NACK the slave stays silent
    hi_seen = 1'b1;
    for (int i = 0; i < 9; i++) begin
      bus_bit(1'b1, r);
      hi_seen = hi_seen & r;
    end
    chk("R9 released after nack", 32'(hi_seen), 32'd1);
    bus_stop;

    // R8: fill all registers and two more bytes past the end
    bus_start;
    put_byte(8'hD4, a); chk("R2 register target ack", 32'(a), 32'd1);
    put_byte(8'h00, a); chk("R7 register addr ack", 32'(a), 32'd1);
    for (int k = 0; k < NREG + 2; k++) begin
      v = 8'(8'h5A ^ (k * 13));
      put_byte(v, a);
      chk("R8 register data ack", 32'(a), 32'd1);
      exp_reg[(k < NREG) ? k : NREG - 1] = v;
    end
    bus_stop;
    bus_start;
    put_byte(8'hD4, a);
    put_byte(8'h00, a);
    bus_start;
    put_byte(8'hD5, a);
    for (int k = 0; k < NREG + 2; k++) begin
      get_byte(k != NREG + 1, d);
      rp = (k < NREG) ? k : NREG - 1;
      chk("R8 register read data", 32'(d), 32'(exp_reg[rp]));
    end
    bus_stop;

    // R7: out-of-range register addresses
    for (int k = 0; k < 4; k++) begin
      g = k * 5 + 3;
      bus_start;
      put_byte(8'hD4, a);
      put_byte(8'(g), a); chk("R7 legal addr ack", 32'(a), 32'd1);
      bus_stop;
      bus_start;
      put_byte(8'hD4, a);
      put_byte(bad_addr[k], a); chk("R7 illegal addr nack", 32'(a), 32'd0);
      put_byte(8'h99, a); chk("R7 abandoned byte nack", 32'(a), 32'd0);
      bus_stop;
      bus_start;
      put_byte(8'hD5, a);
      get_byte(1'b0, d);
      chk("R7 pointer and data kept", 32'(d), 32'(exp_reg[g]));
      bus_stop;
    end
    bus_start;
    put_byte(8'hD4, a);
    put_byte(8'h18, a); chk("R7 last register ack", 32'(a), 32'd1);
    bus_stop;

    // R10: memory pointer untouched by register traffic
    bus_start;
    put_byte(8'hA5, a);
    get_byte(1'b1, d);
    chk("R10 memory pointer kept", 32'(d), 32'(exp_mem[mp]));
    mp = (mp + 1) % NMEM;
    get_byte(1'b0, d);
    chk("R10 memory next byte", 32'(d), 32'(exp_mem[mp]));
    bus_stop;
    waitc(4);
    chk("R1 idle after stop", 32'(sda_oe), 32'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule